// File: doc/BRIEF.md
# EDO DRAM Access Controller

This block sits between a simple host request port and a 32-bit extended-data-out DRAM module made of 4M x 4 parts arranged as two banks. Each accepted host request is a single 32-bit word read or write with a 23-bit word address. The controller turns it into a strobe sequence on an 11-bit multiplexed address bus. The row half of the address goes out under a falling row strobe. The column half follows under falling byte-lane column strobes, with write enable, output enable and a data-drive enable set around them. Every delay is a parameter counted in clock cycles. The defaults suit a 125 MHz clock and the 60 ns speed grade.

After an access the row stays open. A later request to the same bank and row runs as a page cycle with no precharge. A request to another row first closes the open row and precharges it. The open row is also closed when the row strobe comes close to its maximum low time, and when an external refresh engine asks for the memory. In that case the controller closes the row, raises an acknowledge and waits for a done pulse.

The state machine has seven states. `ST_IDLE` means all strobes are high. `ST_ACT` drives the row strobe low with the row address. `ST_COLS` puts the column address out and sets up write enable and data. `ST_CASL` holds the column strobes low. `ST_OPEN` keeps the row open between accesses. `ST_PRE` holds row precharge. `ST_REF` is the refresh hand-off.

The transitions are:
- IDLE goes to REF on a refresh request, and to ACT when it accepts a request.
- ACT goes to COLS after T_RCD cycles.
- COLS goes to CASL after one cycle.
- CASL goes to OPEN after T_CAS cycles.
- OPEN goes to COLS on a page hit.
- OPEN goes to PRE on a miss, a refresh request or the low-time limit.
- PRE goes to IDLE after T_RP cycles.
- REF goes to IDLE on the done pulse.

Top module: `edo_ctrl`

## Requirements
- R1: After reset, all four row strobes and all four column strobes are high, `we_n` and `oe_n` are high, `dq_oe` and `rsp_valid` are low, and `req_ready` is high.
- R2: The request address is split as bank = bit 22, row = bits 21:11 and column = bits 10:0. Bank 0 drives `ras_n[1:0]` low, so `ras_n` = 4'b1100. Bank 1 drives `ras_n[3:2]` low, so `ras_n` = 4'b0011. The row is on `dram_addr` when the row strobe falls, and the column is on `dram_addr` when the column strobes fall.
- R3: A column strobe falls only after the row strobe has been low for at least T_RCD+1 cycles. `dram_addr` stays stable while any column strobe is low.
- R4: For a write, `we_n` is low and `dq_oe` is high at least one cycle before the column strobes fall. `oe_n` stays high whenever `dq_oe` is high. Only the lanes whose `req_be` bit is 1 get a column strobe, and lane i carries data bits 8i+7:8i.
- R5: A read strobes all four lanes with `oe_n` low. It samples `dq_in` at the end of the T_CAS-th column-low cycle. It returns that word on `rsp_rdata` with a one-cycle `rsp_valid` in the next cycle. Read responses come back in request order.
- R6: A request to the open bank and row is served without the row strobe rising.
- R7: A request to a different row or bank closes the open row. The row strobes then stay high for at least T_RP cycles before the next activation.
- R8: Every row-strobe low period lasts at least T_RAS_MIN cycles.
- R9: No row-strobe low period exceeds RAS_LIMIT cycles. A long run of page hits makes the controller close and reopen the row.
- R10: A refresh request wins over host requests at an access boundary. `ref_ack` is high only while all strobes are high. `req_ready` stays low while `ref_ack` is high. `ref_ack` falls in the cycle after `ref_done`.
- R11: Between two column-strobe low periods, all column strobes are high for at least 2 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 23 | Word address {bank, row, column} |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane enables for writes |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 32 | Read data |
| ref_req | input | 1 | Refresh engine wants the memory |
| ref_ack | output | 1 | Memory handed to refresh engine |
| ref_done | input | 1 | Refresh engine finished |
| dram_addr | output | 11 | Multiplexed row/column address |
| ras_n | output | 4 | Row strobes, two per bank |
| cas_n | output | 4 | Column strobes, one per byte lane |
| we_n | output | 1 | Write enable |
| oe_n | output | 1 | Output enable |
| dq_out | output | 32 | Write data to pads |
| dq_oe | output | 1 | Pad drive enable |
| dq_in | input | 32 | Read data from pads |

## Verification
The hardest case to reach is the forced close after a long page run. It needs a row held open for over a thousand cycles by back-to-back hits, with no miss and no refresh to close it first. The bench streams a few hundred reads to one address and counts row-strobe rises during the run. It also records the longest low period seen. The refresh hand-off is reached by raising `ref_req` while a row is open and holding a request on the host port throughout the acknowledge.

// File: rtl/edo_pkg.sv
package edo_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ACT,
        ST_COLS,
        ST_CASL,
        ST_OPEN,
        ST_PRE,
        ST_REF
    } edo_state_e;

    localparam int NUM_BANKS = 2;
    localparam int RAS_PER_BANK = 2;
endpackage

// File: rtl/edo_addr_map.sv
module edo_addr_map #(
    parameter int MA_W = 11
) (
    input  logic [2*MA_W:0]   addr,
    input  logic              open_bank,
    input  logic [MA_W-1:0]   open_row,
    output logic              bank,
    output logic [MA_W-1:0]   row,
    output logic [MA_W-1:0]   col,
    output logic              hit
);
    always_comb begin
        bank = addr[2*MA_W];
        row  = addr[2*MA_W-1:MA_W];
        col  = addr[MA_W-1:0];
        hit  = (bank == open_bank) && (row == open_row);
    end
endmodule

// File: rtl/edo_cyc_timer.sv
module edo_cyc_timer #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/edo_ras_watch.sv
module edo_ras_watch #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         low,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] CMAX = '1;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!low)
            cnt <= '0;
        else if (cnt != CMAX)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
    import edo_pkg::*;
#(
    parameter int MA_W      = 11,
    parameter int LANES     = 4,
    parameter int T_RCD     = 3,
    parameter int T_CAS     = 3,
    parameter int T_RP      = 6,
    parameter int T_RAS_MIN = 8,
    parameter int RAS_LIMIT = 1250
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic                 req_write,
    input  logic [2*MA_W:0]      req_addr,
    input  logic [8*LANES-1:0]   req_wdata,
    input  logic [LANES-1:0]     req_be,
    output logic                 rsp_valid,
    output logic [8*LANES-1:0]   rsp_rdata,
    input  logic                 ref_req,
    output logic                 ref_ack,
    input  logic                 ref_done,
    output logic [MA_W-1:0]      dram_addr,
    output logic [3:0]           ras_n,
    output logic [LANES-1:0]     cas_n,
    output logic                 we_n,
    output logic                 oe_n,
    output logic [8*LANES-1:0]   dq_out,
    output logic                 dq_oe,
    input  logic [8*LANES-1:0]   dq_in
);
    localparam int DW   = 8 * LANES;
    localparam int TMAX = (T_RP > T_RCD) ? ((T_RP > T_CAS) ? T_RP : T_CAS)
                                         : ((T_RCD > T_CAS) ? T_RCD : T_CAS);
    localparam int TW   = $clog2(TMAX + 1);
    localparam int RW   = $clog2(RAS_LIMIT + 2);
    localparam logic [RW-1:0] NEAR_AT = RW'(RAS_LIMIT - T_CAS - 4);
    localparam logic [RW-1:0] MIN_AT  = RW'(T_RAS_MIN - 1);

    edo_state_e state_q, state_d;

    logic             wr_q, bank_q;
    logic [MA_W-1:0]  row_q, col_q;
    logic [DW-1:0]    wdata_q, rdata_q;
    logic [LANES-1:0] be_q;
    logic             rsp_q;

    logic             a_bank, a_hit;
    logic [MA_W-1:0]  a_row, a_col;
    logic             tmr_zero, tmr_load;
    logic [TW-1:0]    tmr_val;
    logic             row_low;
    logic [RW-1:0]    ras_cnt;
    logic             ras_near, ras_min_ok, accept;

    edo_addr_map #(.MA_W(MA_W)) u_map (
        .addr      (req_addr),
        .open_bank (bank_q),
        .open_row  (row_q),
        .bank      (a_bank),
        .row       (a_row),
        .col       (a_col),
        .hit       (a_hit)
    );

    edo_cyc_timer #(.W(TW)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    edo_ras_watch #(.W(RW)) u_watch (
        .clk   (clk),
        .rst_n (rst_n),
        .low   (row_low),
        .cnt   (ras_cnt)
    );

    assign ras_near   = (ras_cnt >= NEAR_AT);
    assign ras_min_ok = (ras_cnt >= MIN_AT);

    // next state and acceptance
    always_comb begin
        state_d = state_q;
        accept  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_req)
                    state_d = ST_REF;
                else if (req_valid) begin
                    accept  = 1'b1;
                    state_d = ST_ACT;
                end
            end
            ST_ACT:  if (tmr_zero) state_d = ST_COLS;
            ST_COLS: state_d = ST_CASL;
            ST_CASL: if (tmr_zero) state_d = ST_OPEN;
            ST_OPEN: begin
                if (ras_near ||
                    (ras_min_ok && (ref_req || (req_valid && !a_hit))))
                    state_d = ST_PRE;
                else if (req_valid && a_hit && !ref_req) begin
                    accept  = 1'b1;
                    state_d = ST_COLS;
                end
            end
            ST_PRE:  if (tmr_zero) state_d = ST_IDLE;
            ST_REF:  if (ref_done) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        tmr_load = (state_d != state_q);
        unique case (state_d)
            ST_ACT:  tmr_val = TW'(T_RCD - 1);
            ST_CASL: tmr_val = TW'(T_CAS - 1);
            ST_PRE:  tmr_val = TW'(T_RP - 1);
            default: tmr_val = '0;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // request and response registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            bank_q  <= 1'b0;
            row_q   <= '0;
            col_q   <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rsp_q   <= 1'b0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                wr_q    <= req_write;
                bank_q  <= a_bank;
                row_q   <= a_row;
                col_q   <= a_col;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
            rsp_q <= (state_q == ST_CASL) && tmr_zero && !wr_q;
            if ((state_q == ST_CASL) && tmr_zero && !wr_q)
                rdata_q <= dq_in;
        end
    end

    // outputs
    always_comb begin
        row_low   = 1'b0;
        ras_n     = 4'hF;
        cas_n     = '1;
        we_n      = 1'b1;
        oe_n      = 1'b1;
        dq_oe     = 1'b0;
        dram_addr = col_q;
        ref_ack   = 1'b0;
        unique case (state_q)
            ST_ACT: begin
                row_low   = 1'b1;
                dram_addr = row_q;
            end
            ST_COLS: begin
                row_low = 1'b1;
                we_n    = !wr_q;
                dq_oe   = wr_q;
            end
            ST_CASL: begin
                row_low = 1'b1;
                we_n    = !wr_q;
                dq_oe   = wr_q;
                oe_n    = wr_q;
                cas_n   = wr_q ? ~be_q : '0;
            end
            ST_OPEN: row_low = 1'b1;
            ST_REF:  ref_ack = 1'b1;
            default: ;
        endcase
        if (row_low)
            ras_n = bank_q ? 4'b0011 : 4'b1100;
    end

    assign req_ready = accept;
    assign rsp_valid = rsp_q;
    assign rsp_rdata = rdata_q;
    assign dq_out    = wdata_q;
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
    parameter int MA_W      = 11,
    parameter int LANES     = 4,
    parameter int T_RCD     = 3,
    parameter int T_RP      = 6,
    parameter int T_RAS_MIN = 8,
    parameter int RAS_LIMIT = 1250
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_ready,
    input logic             ref_ack,
    input logic [MA_W-1:0]  dram_addr,
    input logic [3:0]       ras_n,
    input logic [LANES-1:0] cas_n,
    input logic             we_n,
    input logic             oe_n,
    input logic             dq_oe
);
    localparam int CW = $clog2(RAS_LIMIT + T_RP + 4) + 1;
    localparam logic [CW-1:0] CMAX = '1;

    logic          any_ras, any_cas;
    logic [CW-1:0] lo_cnt, hi_cnt, cas_hi;

    assign any_ras = ~&ras_n;
    assign any_cas = ~&cas_n;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= CW'(T_RP);
            cas_hi <= CW'(2);
        end else begin
            lo_cnt <= any_ras ? ((lo_cnt == CMAX) ? lo_cnt : lo_cnt + 1'b1) : '0;
            hi_cnt <= any_ras ? '0 : ((hi_cnt == CMAX) ? hi_cnt : hi_cnt + 1'b1);
            cas_hi <= any_cas ? '0 : ((cas_hi == CMAX) ? cas_hi : cas_hi + 1'b1);
        end
    end

    a_r2_bank_pair: assert property (@(posedge clk) disable iff (!rst_n)
        any_ras |-> (ras_n == 4'b1100 || ras_n == 4'b0011));
    a_r3_rcd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_cas) |-> lo_cnt >= CW'(T_RCD + 1));
    a_r3_col_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (any_cas && $past(any_cas)) |-> $stable(dram_addr));
    a_r4_early_we: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(any_cas) && !we_n) |-> ($past(!we_n) && $past(dq_oe)));
    a_r4_no_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> oe_n);
    a_r7_precharge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_ras) |-> hi_cnt >= CW'(T_RP));
    a_r8_ras_min: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_ras) |-> lo_cnt >= CW'(T_RAS_MIN));
    a_r9_ras_limit: assert property (@(posedge clk) disable iff (!rst_n)
        lo_cnt <= CW'(RAS_LIMIT));
    a_r10_ack_closed: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> (!any_ras && !any_cas && !req_ready));
    a_r11_cas_gap: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_cas) |-> cas_hi >= CW'(2));
endmodule

bind edo_ctrl edo_ctrl_chk #(
    .MA_W(MA_W), .LANES(LANES), .T_RCD(T_RCD), .T_RP(T_RP),
    .T_RAS_MIN(T_RAS_MIN), .RAS_LIMIT(RAS_LIMIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .ref_ack(ref_ack),
    .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .oe_n(oe_n), .dq_oe(dq_oe)
);

// File: tb/sim_edo_ctrl.sv
module sim_edo_ctrl;
    localparam int T_RCD = 3, T_CAS = 3, T_RP = 6, T_RAS_MIN = 8, RAS_LIMIT = 1250;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic        req_ready;
    logic [22:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [3:0]  req_be = '0;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        ref_req = 1'b0, ref_done = 1'b0, ref_ack;
    logic [10:0] dram_addr;
    logic [3:0]  ras_n, cas_n;
    logic        we_n, oe_n, dq_oe;
    logic [31:0] dq_out;
    logic [31:0] dq_in = '0;

    always #4 clk = ~clk;

    edo_ctrl #(.T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP),
               .T_RAS_MIN(T_RAS_MIN), .RAS_LIMIT(RAS_LIMIT)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .ref_req(ref_req), .ref_ack(ref_ack), .ref_done(ref_done),
        .dram_addr(dram_addr), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
    );

    int n_chk = 0, n_fail = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] seed_word(input logic [22:0] a);
        return {a, 9'h0A5} ^ 32'h3C3C_0000;
    endfunction

    // bench-side memory and scoreboard
    logic [31:0] dmem [logic [22:0]];
    logic [31:0] emem [logic [22:0]];
    logic [31:0] exp_q [$];
    logic [22:0] acc_q [$];

    function automatic logic [31:0] dram_rd(input logic [22:0] k);
        return dmem.exists(k) ? dmem[k] : seed_word(k);
    endfunction
    function automatic logic [31:0] exp_rd(input logic [22:0] k);
        return emem.exists(k) ? emem[k] : seed_word(k);
    endfunction

    task automatic do_req(input bit wr, input logic [22:0] a, input logic [31:0] d, input logic [3:0] be);
        logic [31:0] old;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        forever begin
            #1;
            if (req_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
        acc_q.push_back(a);
        if (wr) begin
            old = exp_rd(a);
            for (int i = 0; i < 4; i++)
                if (be[i]) old[8*i +: 8] = d[8*i +: 8];
            emem[a] = old;
        end else
            exp_q.push_back(exp_rd(a));
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    // DRAM model and monitor
    logic [3:0]  p_ras = 4'hF, p_cas = 4'hF;
    logic        p_we = 1'b1;
    logic        m_bank = 1'b0;
    logic [10:0] m_row = '0;
    logic [22:0] m_key = '0;
    int lo = 0, hi = T_RP, cas_gap = 2, max_lo = 0;
    int ras_falls = 0, ras_rises = 0;

    always @(negedge clk) begin
        if (!rst_n) begin
            p_ras = 4'hF; p_cas = 4'hF; p_we = 1'b1;
            lo = 0; hi = T_RP; cas_gap = 2;
        end else begin
            if (&p_ras && !(&ras_n)) begin
                ras_falls++;
                chk(hi >= T_RP, "R7 precharge", hi, T_RP);
                if (acc_q.size() != 0) begin
                    chk(ras_n == (acc_q[0][22] ? 4'b0011 : 4'b1100), "R2 bank pair", ras_n, acc_q[0][22] ? 4'b0011 : 4'b1100);
                    chk(dram_addr == acc_q[0][21:11], "R2 row address", dram_addr, acc_q[0][21:11]);
                end else chk(1'b0, "R2 unexpected activation", 0, 1);
                m_bank = ras_n[2] == 1'b0;
                m_row  = dram_addr;
            end
            if (!(&p_ras) && &ras_n) begin
                ras_rises++;
                chk(lo >= T_RAS_MIN, "R8 ras low time", lo, T_RAS_MIN);
                chk(lo <= RAS_LIMIT, "R9 ras limit", lo, RAS_LIMIT);
            end
            if (&p_cas && !(&cas_n)) begin
                chk(lo >= T_RCD + 1, "R3 ras to cas", lo, T_RCD + 1);
                chk(cas_gap >= 2, "R11 cas gap", cas_gap, 2);
                m_key = {m_bank, m_row, dram_addr};
                if (acc_q.size() != 0) begin
                    chk(m_key == acc_q[0], "R2 column key", m_key, acc_q[0]);
                    void'(acc_q.pop_front());
                end else chk(1'b0, "R2 unexpected column", 0, 1);
                if (!we_n) begin
                    chk(!p_we && dq_oe && oe_n, "R4 early write", {p_we, dq_oe, oe_n}, 3'b011);
                    for (int i = 0; i < 4; i++)
                        if (!cas_n[i]) begin
                            if (!dmem.exists(m_key)) dmem[m_key] = seed_word(m_key);
                            dmem[m_key][8*i +: 8] = dq_out[8*i +: 8];
                        end
                end else
                    chk(cas_n == 4'h0 && !oe_n, "R5 read lanes", {cas_n, oe_n}, 5'h0);
            end
            dq_in = (!oe_n && !(&cas_n)) ? dram_rd(m_key) : 32'h0;
            if (rsp_valid) begin
                if (exp_q.size() != 0) begin
                    chk(rsp_rdata == exp_q[0], "R5 read data", rsp_rdata, exp_q[0]);
                    void'(exp_q.pop_front());
                end else chk(1'b0, "R5 spurious response", rsp_rdata, 0);
            end
            lo = !(&ras_n) ? lo + 1 : 0;
            hi = !(&ras_n) ? 0 : hi + 1;
            cas_gap = !(&cas_n) ? 0 : cas_gap + 1;
            if (lo > max_lo) max_lo = lo;
            p_ras = ras_n; p_cas = cas_n; p_we = we_n;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        int f0, r0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(ras_n == 4'hF && cas_n == 4'hF, "R1 strobes idle", {ras_n, cas_n}, 8'hFF);
        chk(we_n && oe_n && !dq_oe && !rsp_valid, "R1 controls idle", {we_n, oe_n, dq_oe, rsp_valid}, 4'b1100);
        req_valid = 1'b1; #1;
        chk(req_ready, "R1 ready after reset", req_ready, 1);
        req_valid = 1'b0;

        // R6 write then read same row: one activation
        f0 = ras_falls;
        do_req(1'b1, {1'b0, 11'd5, 11'd10}, 32'hDEAD_BEEF, 4'hF);
        do_req(1'b0, {1'b0, 11'd5, 11'd10}, '0, 4'hF);
        drain();
        chk(ras_falls - f0 == 1, "R6 page hit no reopen", ras_falls - f0, 1);

        // R4 partial write merges lanes
        do_req(1'b1, {1'b0, 11'd5, 11'd10}, 32'h1122_3344, 4'b0101);
        do_req(1'b0, {1'b0, 11'd5, 11'd10}, '0, 4'hF);
        drain();

        // R7 row miss
        r0 = ras_rises; f0 = ras_falls;
        do_req(1'b0, {1'b0, 11'd6, 11'd3}, '0, 4'hF);
        drain();
        chk(ras_rises > r0 && ras_falls - f0 == 1, "R7 miss closes row", ras_rises - r0, 1);

        // R2 bank 1 and a bank switch
        do_req(1'b1, {1'b1, 11'h7FF, 11'h7FF}, 32'hCAFE_0001, 4'b1010);
        do_req(1'b0, {1'b1, 11'h7FF, 11'h7FF}, '0, 4'hF);
        do_req(1'b0, {1'b0, 11'd5, 11'd10}, '0, 4'hF);
        for (int i = 0; i < 6; i++)
            do_req(i[0], {i[1], 11'(i * 37), 11'(i * 91)}, 32'h0F0F_0000 + i, 4'hF);
        for (int i = 0; i < 6; i++)
            do_req(1'b0, {i[1], 11'(i * 37), 11'(i * 91)}, '0, 4'hF);
        drain();

        // R10 refresh with row open
        @(negedge clk);
        ref_req = 1'b1;
        for (int i = 0; i < 60 && !ref_ack; i++) @(negedge clk);
        chk(ref_ack, "R10 ack given", ref_ack, 1);
        chk(ras_n == 4'hF && cas_n == 4'hF, "R10 rows closed at ack", {ras_n, cas_n}, 8'hFF);
        req_valid = 1'b1; req_write = 1'b0; req_addr = {1'b0, 11'd5, 11'd10};
        for (int i = 0; i < 3; i++) begin
            @(negedge clk); #1;
            chk(!req_ready && ref_ack, "R10 host held off", {req_ready, ref_ack}, 2'b01);
        end
        req_valid = 1'b0;
        ref_req = 1'b0; ref_done = 1'b1;
        @(negedge clk);
        ref_done = 1'b0;
        chk(!ref_ack, "R10 ack drops after done", ref_ack, 0);

        // R9 long page run
        r0 = ras_rises;
        for (int i = 0; i < 300; i++)
            do_req(1'b0, {1'b0, 11'd5, 11'd10}, '0, 4'hF);
        drain();
        chk(ras_rises > r0, "R9 forced close", ras_rises - r0, 1);
        chk(max_lo <= RAS_LIMIT, "R9 max low time", max_lo, RAS_LIMIT);
        chk(exp_q.size() == 0, "R5 all responses returned", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end
endmodule